// File: doc/BRIEF.md
# Hash Engine Control Register Slice

This block is the control-word and status slice of a hash accelerator. It sits on a simple 32-bit register bus and holds the configuration that a hash core needs: algorithm, plain or keyed (HMAC) mode, input data type, DMA enable, key length and multi-transfer DMA policy. It turns bus commands into one-cycle start and finish pulses for the core. It also forwards each data word written to the input register.

A data-present flag tracks whether the input register has been written since the last start or finish. The key-length choice reaches the core only when a computation is started in HMAC mode, so rewriting it mid-message has no effect. A DMA-completion pulse from outside raises the finish pulse by itself unless multi-transfer mode is selected.

Bus writes take effect at the clock edge where `bus_we` is high. All outputs except `bus_rdata` are registered, so they change at that edge. `bus_rdata` is a combinational read of the addressed register. Offsets: 0x0 control word, 0x4 data input (write only, reads 0), 0x8 command (write only, reads 0).

Top module: `hash_ctrl_regs`

## Requirements
- R1: After reset the control word reads 0x00000000 (with `core_nbw` at 0), and `core_start`, `core_finish`, `core_din_valid` and every configuration output are 0.
- R2: Control-word bits 31:19, bit 17, bits 15:14 and bits 1:0 always read 0, and writes to them are ignored.
- R3: Writable control fields read back what was written and drive the configuration outputs: bit 3 DMA enable, bits 5:4 data type, bit 6 HMAC mode, bit 7 algorithm bit 0, bit 18 algorithm bit 1, bit 13 multi-transfer DMA, bit 16 key-length request.
- R4: Writing 1 to control bit 2 (start) gives `core_start` high for exactly the cycle after the write. Bit 2 always reads 0.
- R5: Control bits 11:8 read the `core_nbw` input, and bus writes to them are ignored.
- R6: Control bit 12 (data present) becomes 1 after a write to offset 0x4. It is read-only.
- R7: The data-present flag returns to 0 on a start write or on any finish pulse. A clear wins over a data write in the same cycle.
- R8: Writing 1 to bit 0 at offset 0x8 gives `core_finish` high for exactly the cycle after the write.
- R9: A `dma_done` pulse while bit 13 is 0 gives the same one-cycle `core_finish`. While bit 13 is 1 it gives none.
- R10: `cfg_key_long` changes only on a start write. It takes written bit 16 if written bit 6 is 1 in that same word, and 0 otherwise.
- R11: A write to offset 0x4 gives `core_din_valid` for one cycle with `core_din` equal to the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| core_nbw | input | 4 | Valid-bit count reported by the core |
| dma_done | input | 1 | DMA transfer completion pulse |
| cfg_algo | output | 2 | Selected algorithm |
| cfg_hmac | output | 1 | Keyed mode selected |
| cfg_dtype | output | 2 | Input data type |
| cfg_dma_en | output | 1 | DMA requests enabled |
| cfg_key_long | output | 1 | Key length captured at start (1 = longer than 64 bytes) |
| core_start | output | 1 | One-cycle start pulse |
| core_finish | output | 1 | One-cycle digest-calculation pulse |
| core_din_valid | output | 1 | One-cycle data-word strobe |
| core_din | output | 32 | Forwarded data word |

## Verification
The bus carries one write per cycle, so a data-input write can coincide only with the `dma_done` finish, not with a bus start or finish. The bench raises `dma_done` in the same cycle as a write to offset 0x4 while bit 13 is 0. It then requires three things: the word is forwarded, one finish pulse appears, and the flag reads 0 because the clear wins. In a second coincidence, a software finish write lands together with `dma_done`. The bench requires a single finish pulse that lasts exactly one cycle.

// File: rtl/hash_ctrl_pkg.sv
// Package: register offsets, bit positions and the stored control word type
// shared by the control-register slice and its checker.
package hash_ctrl_pkg;
    localparam int DATA_W   = 32;
    localparam int NBW_W    = 4;

    localparam int OFF_CTRL = 'h0;
    localparam int OFF_DIN  = 'h4;
    localparam int OFF_CMD  = 'h8;

    localparam int B_INIT   = 2;
    localparam int B_DMAE   = 3;
    localparam int B_DTYPE  = 4;   // two bits
    localparam int B_MODE   = 6;
    localparam int B_ALGO0  = 7;
    localparam int B_NBW    = 8;   // NBW_W bits
    localparam int B_FULL   = 12;
    localparam int B_MULTI  = 13;
    localparam int B_KEY    = 16;
    localparam int B_ALGO1  = 18;
    localparam int B_FIN    = 0;   // in the command register

    localparam logic [DATA_W-1:0] RSV_MASK = 32'hFFFA_C003;

    typedef struct packed {
        logic [1:0] algo;
        logic       key_req;
        logic       multi_dma;
        logic       hmac;
        logic [1:0] dtype;
        logic       dma_en;
    } ctrl_t;
endpackage

// File: rtl/hash_ctrl_cfg.sv
// Control word storage. Holds the writable fields and latches the key-length
// choice at start time. Assumes one write per cycle, decoded by the parent.
module hash_ctrl_cfg
    import hash_ctrl_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_ctrl,
    input  logic [W-1:0] wdata,
    output ctrl_t        ctrl_q,
    output logic         key_long_q,
    output logic         init_req
);
    ctrl_t ctrl_d;

    // Start request is a write-one pulse, never stored.
    assign init_req = wr_ctrl && wdata[B_INIT];

    // Unpack the writable fields from the bus word.
    always_comb begin
        ctrl_d.algo      = {wdata[B_ALGO1], wdata[B_ALGO0]};
        ctrl_d.key_req   = wdata[B_KEY];
        ctrl_d.multi_dma = wdata[B_MULTI];
        ctrl_d.hmac      = wdata[B_MODE];
        ctrl_d.dtype     = wdata[B_DTYPE +: 2];
        ctrl_d.dma_en    = wdata[B_DMAE];
    end

    // Store the control word on a control-register write.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_d;
    end

    // Capture the key length only at start; plain mode forces a short key.
    always_ff @(posedge clk) begin
        if (!rst_n)        key_long_q <= 1'b0;
        else if (init_req) key_long_q <= wdata[B_MODE] && wdata[B_KEY];
    end
endmodule

// File: rtl/hash_ctrl_seq.sv
// Command sequencing: start/finish pulses, data-present flag and data-word
// forwarding. Assumes init, software finish and data writes are mutually
// exclusive (single bus); dma_done may coincide with any of them.
module hash_ctrl_seq #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_req,
    input  logic         fin_req,
    input  logic         din_wr,
    input  logic [W-1:0] wdata,
    input  logic         dma_done,
    input  logic         multi_dma,
    output logic         din_full,
    output logic         start_o,
    output logic         finish_o,
    output logic         din_vld_o,
    output logic [W-1:0] din_o
);
    logic fin_any;

    // A DMA completion finishes the message unless multi-transfer is set.
    assign fin_any = fin_req || (dma_done && !multi_dma);

    // Register the one-cycle pulses toward the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_o   <= 1'b0;
            finish_o  <= 1'b0;
            din_vld_o <= 1'b0;
        end else begin
            start_o   <= init_req;
            finish_o  <= fin_any;
            din_vld_o <= din_wr;
        end
    end

    // Hold the last written data word for the core.
    always_ff @(posedge clk) begin
        if (!rst_n)      din_o <= '0;
        else if (din_wr) din_o <= wdata;
    end

    // Data-present flag: a clear takes priority over a set.
    always_ff @(posedge clk) begin
        if (!rst_n)                     din_full <= 1'b0;
        else if (init_req || fin_any)   din_full <= 1'b0;
        else if (din_wr)                din_full <= 1'b1;
    end
endmodule

// File: rtl/hash_ctrl_regs.sv
// Top of the hash control-register slice: address decode, readback mux and
// the two sub-blocks. Reads are combinational, writes take one edge.
module hash_ctrl_regs
    import hash_ctrl_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NBW_W-1:0]  core_nbw,
    input  logic              dma_done,
    output logic [1:0]        cfg_algo,
    output logic              cfg_hmac,
    output logic [1:0]        cfg_dtype,
    output logic              cfg_dma_en,
    output logic              cfg_key_long,
    output logic              core_start,
    output logic              core_finish,
    output logic              core_din_valid,
    output logic [31:0]       core_din
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_DIN  = ADDR_W'(OFF_DIN);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFF_CMD);

    ctrl_t ctrl_q;
    logic  wr_ctrl, wr_din, fin_req, init_req, din_full, multi_dma;

    // Decode writes to the three offsets.
    assign wr_ctrl   = bus_we && (bus_addr == A_CTRL);
    assign wr_din    = bus_we && (bus_addr == A_DIN);
    assign fin_req   = bus_we && (bus_addr == A_CMD) && bus_wdata[B_FIN];
    assign multi_dma = ctrl_q.multi_dma;

    hash_ctrl_cfg #(.W(DATA_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (wr_ctrl),
        .wdata      (bus_wdata),
        .ctrl_q     (ctrl_q),
        .key_long_q (cfg_key_long),
        .init_req   (init_req)
    );

    hash_ctrl_seq #(.W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_req  (init_req),
        .fin_req   (fin_req),
        .din_wr    (wr_din),
        .wdata     (bus_wdata),
        .dma_done  (dma_done),
        .multi_dma (multi_dma),
        .din_full  (din_full),
        .start_o   (core_start),
        .finish_o  (core_finish),
        .din_vld_o (core_din_valid),
        .din_o     (core_din)
    );

    // Drive configuration outputs from the stored word.
    assign cfg_algo   = ctrl_q.algo;
    assign cfg_hmac   = ctrl_q.hmac;
    assign cfg_dtype  = ctrl_q.dtype;
    assign cfg_dma_en = ctrl_q.dma_en;

    // Readback: only the control word returns data; reserved bits stay 0.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL) begin
            bus_rdata[B_DMAE]          = ctrl_q.dma_en;
            bus_rdata[B_DTYPE +: 2]    = ctrl_q.dtype;
            bus_rdata[B_MODE]          = ctrl_q.hmac;
            bus_rdata[B_ALGO0]         = ctrl_q.algo[0];
            bus_rdata[B_NBW +: NBW_W]  = core_nbw;
            bus_rdata[B_FULL]          = din_full;
            bus_rdata[B_MULTI]         = ctrl_q.multi_dma;
            bus_rdata[B_KEY]           = ctrl_q.key_req;
            bus_rdata[B_ALGO1]         = ctrl_q.algo[1];
        end
    end
endmodule

// File: rtl/hash_ctrl_regs_chk.sv
// Checker for hash_ctrl_regs, attached with bind. Observes ports plus the
// internal flag and multi-transfer bit.
module hash_ctrl_regs_chk
    import hash_ctrl_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              dma_done,
    input logic              multi_dma,
    input logic              din_full,
    input logic              cfg_key_long,
    input logic              core_start,
    input logic              core_finish
);
    p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_CTRL)) |-> ((bus_rdata & RSV_MASK) == '0));

    p_start_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start);

    p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (core_start || core_finish) |-> !din_full);

    p_finish_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        core_finish |=> !core_finish);

    p_dma_auto_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_done && !multi_dma) |=> core_finish);

    p_key_at_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_key_long) |-> core_start);
endmodule

bind hash_ctrl_regs hash_ctrl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .dma_done     (dma_done),
    .multi_dma    (multi_dma),
    .din_full     (din_full),
    .cfg_key_long (cfg_key_long),
    .core_start   (core_start),
    .core_finish  (core_finish)
);

// File: tb/hash_ctrl_regs_tb.sv
module hash_ctrl_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  core_nbw = '0;
    logic        dma_done = 1'b0;
    logic [1:0]  cfg_algo, cfg_dtype;
    logic        cfg_hmac, cfg_dma_en, cfg_key_long;
    logic        core_start, core_finish, core_din_valid;
    logic [31:0] core_din;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hash_ctrl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_nbw(core_nbw),
        .dma_done(dma_done), .cfg_algo(cfg_algo), .cfg_hmac(cfg_hmac),
        .cfg_dtype(cfg_dtype), .cfg_dma_en(cfg_dma_en),
        .cfg_key_long(cfg_key_long), .core_start(core_start),
        .core_finish(core_finish), .core_din_valid(core_din_valid),
        .core_din(core_din)
    );

    // {addr, wdata, expected control word afterwards}, core_nbw = 4'hA
    localparam logic [67:0] VEC [7] = '{
        {4'h0, 32'hFFFF_FFFF, 32'h0005_2AF8},
        {4'h4, 32'h1234_5678, 32'h0005_3AF8},
        {4'h0, 32'h0000_0000, 32'h0000_1A00},
        {4'h8, 32'h0000_0001, 32'h0000_0A00},
        {4'h4, 32'hCAFE_0001, 32'h0000_1A00},
        {4'h0, 32'h0000_0004, 32'h0000_0A00},
        {4'h0, 32'h0004_2040, 32'h0004_2A40}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 4'h0; bus_wdata = '0;
        #0.5;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        // R1: reset state
        check("R1 ctrl", bus_rdata, 32'h0);
        check("R1 pulses", {29'd0, core_start, core_finish, core_din_valid}, 32'h0);
        check("R1 cfg", {25'd0, cfg_algo, cfg_hmac, cfg_dtype, cfg_dma_en, cfg_key_long}, 32'h0);

        // R2 R3 R5 R6 R7: table walk
        core_nbw = 4'hA;
        for (int i = 0; i < 7; i++) begin
            wr(VEC[i][67:64], VEC[i][63:32]);
            check($sformatf("R2 R3 R5 R6 R7 vec%0d", i), bus_rdata, VEC[i][31:0]);
        end
        // R3: outputs follow last word (algo=2, hmac=1, dtype=0, dmae=0)
        check("R3 cfg", {28'd0, cfg_algo, cfg_hmac, cfg_dma_en}, 32'h0000_000A);

        // R4: start pulse lasts one cycle, R10: key latched in HMAC mode
        wr(4'h0, 32'h0001_0044);
        check("R4 start high", {31'd0, core_start}, 32'h1);
        check("R4 reads zero", bus_rdata & 32'h4, 32'h0);
        check("R10 key long", {31'd0, cfg_key_long}, 32'h1);
        @(negedge clk); #0.5;
        check("R4 start low", {31'd0, core_start}, 32'h0);

        // R10: key change without start has no effect
        wr(4'h0, 32'h0000_0040);
        check("R10 no start", {31'd0, cfg_key_long}, 32'h1);
        // R10: start in plain mode forces short key
        wr(4'h0, 32'h0001_0004);
        check("R10 plain", {31'd0, cfg_key_long}, 32'h0);

        // R8 R11: software finish and data forwarding
        wr(4'h4, 32'hDEAD_BEEF);
        check("R11 valid", {31'd0, core_din_valid}, 32'h1);
        check("R11 data", core_din, 32'hDEAD_BEEF);
        wr(4'h8, 32'h0000_0001);
        check("R8 finish", {31'd0, core_finish}, 32'h1);
        @(negedge clk); #0.5;
        check("R8 finish low", {31'd0, core_finish}, 32'h0);

        // R9: dma_done with multi-transfer off
        @(negedge clk); dma_done = 1'b1;
        @(negedge clk); dma_done = 1'b0; #0.5;
        check("R9 auto finish", {31'd0, core_finish}, 32'h1);

        // R7: data write and DMA finish in the same cycle: clear wins
        @(negedge clk);
        dma_done = 1'b1; bus_we = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h0BAD_F00D;
        @(negedge clk);
        dma_done = 1'b0; bus_we = 1'b0; bus_addr = 4'h0; #0.5;
        check("R7 collide flag", bus_rdata & 32'h1000, 32'h0);
        check("R7 collide finish", {30'd0, core_finish, core_din_valid}, 32'h3);

        // R8 R9: software finish coincides with dma_done: one single pulse
        @(negedge clk);
        dma_done = 1'b1; bus_we = 1'b1; bus_addr = 4'h8; bus_wdata = 32'h1;
        @(negedge clk);
        dma_done = 1'b0; bus_we = 1'b0; bus_addr = 4'h0; #0.5;
        check("R8 R9 both", {31'd0, core_finish}, 32'h1);
        @(negedge clk); #0.5;
        check("R8 R9 single", {31'd0, core_finish}, 32'h0);

        // R9: multi-transfer on suppresses the auto finish; flag stays set
        wr(4'h0, 32'h0000_2000);
        wr(4'h4, 32'h0000_0001);
        @(negedge clk); dma_done = 1'b1;
        @(negedge clk); dma_done = 1'b0; #0.5;
        check("R9 multi none", {31'd0, core_finish}, 32'h0);
        check("R9 R6 flag kept", bus_rdata & 32'h1000, 32'h1000);

        // R6: writing the flag bit itself has no effect
        wr(4'h8, 32'h1);
        wr(4'h0, 32'h0000_1000);
        check("R6 read only", bus_rdata & 32'h1000, 32'h0);

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end
endmodule